// File: doc/BRIEF.md
# BCD Digit to Serial Word Formatter

This block turns the digit-multiplexed BCD output of an integrating converter into byte-wide words for a UART transmitter. The converter scans its result one digit at a time. For each digit it drives a one-hot digit-select bus and a 4-bit BCD value, and it gives one active-low strobe pulse per digit after every conversion. The block looks for the falling edge of that strobe. On that edge it captures the digit, puts a digit tag in the upper nibble of the outgoing word, and sends the transmitter a single-cycle load request.

The reading's sign is not placed in the data. It goes out on the transmitter's even-parity-enable line, and the receiver keeps a fixed parity setting. Seeing a parity flag at the receiver therefore means the reading was positive.

The `EXTENDED` parameter selects the variant. In the extended variant, the sign, over-range and under-range flags are packed into the most significant digit's word, because that digit only ever uses its lowest bit. The extended variant also keeps a conversion-request latch. A request byte from the receiver sets the latch, and the latch drives the converter's run/hold input. The latch clears when the converter's busy output falls. The non-extended variant holds run/hold high, so the converter converts continuously.

Top module: `bcd_uart_fmt`

## Requirements
- R1: While `rst_n` is low, `tx_load`, `tx_data`, `even_par_en` and `overrun_err` are all zero. In the extended variant `run_hold` is also zero; in the basic variant it is one.
- R2: A high-to-low transition of `strobe_n`, sampled on a rising clock edge, makes `tx_load` high for exactly one clock cycle, starting after that edge. Holding `strobe_n` low longer produces no further pulse.
- R3: `tx_data[3:0]` carries the BCD digit captured with the strobe. `tx_data[7:4]` carries the digit tag, which is the bit-reversed digit index. With `digit_sel[4]`=D5, `digit_sel[3]`=D4 and so on down to `digit_sel[0]`=D1, the tags are D5=0000, D4=1000, D3=0100, D2=1100 and D1=0010.
- R4: In the extended variant, the D5 word's low nibble is {pol, ovr, und, bcd[0]}, with bit 3 the sign, bit 2 over-range and bit 1 under-range. The other words, and every word of the basic variant, carry the plain BCD digit.
- R5: `even_par_en` takes the value of `pol` captured with the strobe, and it is valid while `tx_load` is high.
- R6: If `tx_busy` is high at the strobe edge, `overrun_err` goes high and stays high until reset. A strobe with `tx_busy` low leaves it unchanged.
- R7: In the extended variant, an `rx_req` pulse sets `run_hold` on the next cycle. A falling edge of `conv_busy` clears it one cycle later, and a rising edge of `conv_busy` has no effect. If a request and a fall coincide, the request wins.
- R8: `tx_data` and `even_par_en` change only in the cycle in which `tx_load` is high, and hold their value between loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n | input | 1 | Converter digit strobe, active low |
| digit_sel | input | DIGITS (5) | One-hot digit select, MSB = most significant digit |
| bcd | input | BCD_W (4) | BCD value of the selected digit |
| pol | input | 1 | Reading sign, 1 = positive |
| ovr | input | 1 | Over-range flag |
| und | input | 1 | Under-range flag |
| tx_busy | input | 1 | Transmitter still sending the previous word |
| rx_req | input | 1 | Single-cycle pulse: conversion request byte received |
| conv_busy | input | 1 | Converter busy output |
| tx_data | output | TAG_W+BCD_W (8) | Word presented to the transmitter |
| tx_load | output | 1 | Single-cycle load request |
| even_par_en | output | 1 | Transmitter even-parity enable |
| overrun_err | output | 1 | Sticky overrun error |
| run_hold | output | 1 | Converter run/hold control |

## Verification
The assertions take the converter's signals as well formed. `digit_sel` is exactly one-hot when a strobe edge is seen, and `strobe_n` returns high between digits. `rx_req` is a single-cycle pulse. The stimulus always changes `digit_sel`, `bcd` and the flags together with the falling strobe edge, and never leaves the select bus empty or with several bits set. All inputs are driven on the falling clock edge, so each strobe edge is sampled exactly once.

// File: rtl/bcd_fmt_pkg.sv
package bcd_fmt_pkg;

   // status flags carried with a reading
   typedef struct packed {
      logic pol;
      logic ovr;
      logic und;
   } conv_flags_t;

   localparam int unsigned FLAG_COUNT = $bits(conv_flags_t);

endpackage

// File: rtl/strobe_catch.sv
module strobe_catch (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe_n,
   output logic fire
);

   logic strobe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strobe_q <= 1'b1;
      else        strobe_q <= strobe_n;
   end

   assign fire = strobe_q & ~strobe_n;

   // R2
   fire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);

endmodule

// File: rtl/word_builder.sv
module word_builder
   import bcd_fmt_pkg::*;
#(
   parameter int unsigned DIGITS   = 5,
   parameter int unsigned BCD_W    = 4,
   parameter int unsigned TAG_W    = 4,
   parameter bit          EXTENDED = 1'b1,
   localparam int unsigned WORD_W  = TAG_W + BCD_W
) (
   input  logic [DIGITS-1:0] digit_sel,
   input  logic [BCD_W-1:0]  bcd,
   input  conv_flags_t       flags,
   output logic [WORD_W-1:0] word
);

   logic [TAG_W-1:0] index;
   logic [TAG_W-1:0] tag;
   logic [BCD_W-1:0] payload;

   // digit index: most significant digit is index 0
   always_comb begin
      index = '0;
      for (int i = 0; i < DIGITS; i++) begin
         if (digit_sel[i]) index = TAG_W'(DIGITS - 1 - i);
      end
   end

   // tag is the bit-reversed index
   for (genvar j = 0; j < TAG_W; j++) begin : g_rev
      assign tag[j] = index[TAG_W-1-j];
   end

   if (EXTENDED) begin : g_ext
      always_comb begin
         if (digit_sel[DIGITS-1]) payload = {flags, bcd[BCD_W-FLAG_COUNT-1:0]};
         else                     payload = bcd;
      end
   end else begin : g_basic
      assign payload = bcd;
   end

   assign word = {tag, payload};

endmodule

// File: rtl/run_request.sv
module run_request (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_req,
   input  logic conv_busy,
   output logic run_hold
);

   logic busy_q;
   logic req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         req_q  <= 1'b0;
      end else begin
         busy_q <= conv_busy;
         if (rx_req)                    req_q <= 1'b1;
         else if (busy_q && !conv_busy) req_q <= 1'b0;
      end
   end

   assign run_hold = req_q;

   // R7
   req_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_req |=> run_hold);

   // R7
   req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(conv_busy) && !rx_req) |=> !run_hold);

   // R7
   busy_rise_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(conv_busy) && run_hold) |=> run_hold);

endmodule

// File: rtl/bcd_uart_fmt.sv
module bcd_uart_fmt
   import bcd_fmt_pkg::*;
#(
   parameter int unsigned DIGITS   = 5,
   parameter int unsigned BCD_W    = 4,
   parameter int unsigned TAG_W    = 4,
   parameter bit          EXTENDED = 1'b1,
   localparam int unsigned WORD_W  = TAG_W + BCD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              strobe_n,
   input  logic [DIGITS-1:0] digit_sel,
   input  logic [BCD_W-1:0]  bcd,
   input  logic              pol,
   input  logic              ovr,
   input  logic              und,
   input  logic              tx_busy,
   input  logic              rx_req,
   input  logic              conv_busy,
   output logic [WORD_W-1:0] tx_data,
   output logic              tx_load,
   output logic              even_par_en,
   output logic              overrun_err,
   output logic              run_hold
);

   if (DIGITS < 2 || DIGITS > (1 << TAG_W)) begin : g_bad_digits
      $error("DIGITS must fit the tag width");
   end
   if (EXTENDED && BCD_W < FLAG_COUNT + 1) begin : g_bad_bcd
      $error("BCD_W too narrow for flag insertion");
   end

   conv_flags_t       flags;
   logic              fire;
   logic [WORD_W-1:0] word;

   assign flags = '{pol: pol, ovr: ovr, und: und};

   strobe_catch u_catch (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe_n (strobe_n),
      .fire     (fire)
   );

   word_builder #(
      .DIGITS   (DIGITS),
      .BCD_W    (BCD_W),
      .TAG_W    (TAG_W),
      .EXTENDED (EXTENDED)
   ) u_word (
      .digit_sel (digit_sel),
      .bcd       (bcd),
      .flags     (flags),
      .word      (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_data     <= '0;
         tx_load     <= 1'b0;
         even_par_en <= 1'b0;
         overrun_err <= 1'b0;
      end else begin
         tx_load <= fire;
         if (fire) begin
            tx_data     <= word;
            even_par_en <= pol;
            if (tx_busy) overrun_err <= 1'b1;
         end
      end
   end

   if (EXTENDED) begin : g_req
      run_request u_req (
         .clk       (clk),
         .rst_n     (rst_n),
         .rx_req    (rx_req),
         .conv_busy (conv_busy),
         .run_hold  (run_hold)
      );
   end else begin : g_free_run
      assign run_hold = 1'b1;
   end

   // R3
   digit_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |-> $onehot(digit_sel));

   // R2
   load_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> !tx_load);

   // R5
   parity_follows_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |-> even_par_en == $past(pol));

   // R6
   overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun_err |=> overrun_err);

   // R8
   data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_load |-> ($stable(tx_data) && $stable(even_par_en)));

endmodule

// File: tb/test_bcd_uart_fmt.sv
module test_bcd_uart_fmt;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       strobe_n = 1'b1;
   logic [4:0] digit_sel = 5'b10000;
   logic [3:0] bcd = 4'd0;
   logic       pol = 1'b0, ovr = 1'b0, und = 1'b0;
   logic       tx_busy = 1'b0, rx_req = 1'b0, conv_busy = 1'b0;

   logic [7:0] tx_data, tx_data_b;
   logic       tx_load, tx_load_b, even_par_en, even_par_en_b;
   logic       overrun_err, overrun_err_b, run_hold, run_hold_b;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   bcd_uart_fmt i_bcd_uart_fmt (
      .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .digit_sel(digit_sel),
      .bcd(bcd), .pol(pol), .ovr(ovr), .und(und), .tx_busy(tx_busy),
      .rx_req(rx_req), .conv_busy(conv_busy), .tx_data(tx_data),
      .tx_load(tx_load), .even_par_en(even_par_en),
      .overrun_err(overrun_err), .run_hold(run_hold)
   );

   bcd_uart_fmt #(.EXTENDED(1'b0)) i_bcd_uart_fmt_basic (
      .clk(clk), .rst_n(rst_n), .strobe_n(strobe_n), .digit_sel(digit_sel),
      .bcd(bcd), .pol(pol), .ovr(ovr), .und(und), .tx_busy(tx_busy),
      .rx_req(rx_req), .conv_busy(conv_busy), .tx_data(tx_data_b),
      .tx_load(tx_load_b), .even_par_en(even_par_en_b),
      .overrun_err(overrun_err_b), .run_hold(run_hold_b)
   );

   // {digit_sel, bcd, pol, ovr, und, expected extended word}
   localparam int NVEC = 10;
   localparam logic [19:0] VEC [NVEC] = '{
      {5'b10000, 4'b0001, 3'b100, 8'h09},
      {5'b01000, 4'b0111, 3'b100, 8'h87},
      {5'b00100, 4'b1001, 3'b100, 8'h49},
      {5'b00010, 4'b0000, 3'b100, 8'hC0},
      {5'b00001, 4'b0101, 3'b100, 8'h25},
      {5'b10000, 4'b0000, 3'b010, 8'h04},
      {5'b10000, 4'b0001, 3'b001, 8'h03},
      {5'b01000, 4'b1000, 3'b000, 8'h88},
      {5'b00001, 4'b1001, 3'b000, 8'h29},
      {5'b10000, 4'b0000, 3'b111, 8'h0E}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic strobe_digit(input logic [4:0] s, input logic [3:0] b,
                               input logic [2:0] f, input logic [7:0] exp);
      logic [7:0] exp_b;
      exp_b = {exp[7:4], b};
      @(negedge clk);
      digit_sel = s; bcd = b; {pol, ovr, und} = f; strobe_n = 1'b0;
      @(negedge clk);
      check("R2 load pulse", tx_load, 1'b1);
      check("R3/R4 word", tx_data, exp);
      check("R3/R4 basic word", tx_data_b, exp_b);
      check("R5 parity", even_par_en, f[2]);
      @(negedge clk);
      check("R2 single pulse", tx_load, 1'b0);
      strobe_n = 1'b1;
      @(negedge clk);
      check("R8 data hold", tx_data, exp);
      check("R8 parity hold", even_par_en, f[2]);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 tx_load", tx_load, 1'b0);
      check("R1 tx_data", tx_data, 8'h00);
      check("R1 parity", even_par_en, 1'b0);
      check("R1 overrun", overrun_err, 1'b0);
      check("R1 run_hold ext", run_hold, 1'b0);
      check("R1 run_hold basic", run_hold_b, 1'b1);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int k = 0; k < NVEC; k++) begin
         strobe_digit(VEC[k][19:15], VEC[k][14:11], VEC[k][10:8], VEC[k][7:0]);
      end
      // R6: no strobe so far saw a busy transmitter
      check("R6 no overrun", overrun_err, 1'b0);

      // R6 overrun on busy transmitter, then sticky
      tx_busy = 1'b1;
      strobe_digit(5'b00100, 4'b0011, 3'b000, 8'h43);
      check("R6 overrun set", overrun_err, 1'b1);
      check("R6 overrun basic", overrun_err_b, 1'b1);
      tx_busy = 1'b0;
      strobe_digit(5'b00010, 4'b0010, 3'b100, 8'hC2);
      check("R6 overrun sticky", overrun_err, 1'b1);

      // R7 request latch
      @(negedge clk); rx_req = 1'b1;
      @(negedge clk); rx_req = 1'b0;
      check("R7 set", run_hold, 1'b1);
      conv_busy = 1'b1;
      repeat (2) @(negedge clk);
      check("R7 busy rise ignored", run_hold, 1'b1);
      conv_busy = 1'b0;
      @(negedge clk);
      check("R7 clear on busy fall", run_hold, 1'b0);
      check("R7 basic free run", run_hold_b, 1'b1);

      // R7 request wins over coincident busy fall
      @(negedge clk); rx_req = 1'b1; conv_busy = 1'b1;
      @(negedge clk); rx_req = 1'b1; conv_busy = 1'b0;
      @(negedge clk); rx_req = 1'b0;
      check("R7 request priority", run_hold, 1'b1);

      // R1 reset clears sticky error
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 overrun cleared", overrun_err, 1'b0);
      check("R1 run_hold cleared", run_hold, 1'b0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule